// File: doc/BRIEF.md
# USB Device Command and Status Register

This block is the 32-bit control and status word of a full-speed USB device controller. Software reaches it through a simple register port: a write strobe with write data, and read data that always shows the current contents. The word holds the function address with its enable, the interrupt-on-NAK enables for four endpoint classes, the connect request, a forced clock request and an LPM-capable flag. It also holds four sticky event flags that hardware sets and software clears by writing a one.

Beside the register the block filters the raw VBUS level. The filtered level rises on the next clock edge after VBUS is seen high. It falls only after a configurable number of millisecond ticks pass with VBUS low. The pull-up request to the PHY is the connect bit gated by this filtered level. A pending SETUP flag tells the packet engine to NAK every IN and OUT token until software clears the flag.

Top module: `usbd_cmdstat`

## Requirements
- R1: Reset. After reset the read data is 0x00000800: the LPM-capable bit 11 is one and every other bit is zero. `pullup_en`, `nak_all`, `clk_req` and the three change outputs are low.
- R2: Writable fields. A write stores these fields, each readable at its own position: address at bits 6:0 (on `dev_addr`), enable at bit 7 (on `dev_active`), force-clock at bit 9, LPM-capable at bit 11, NAK-interrupt enables at bits 12..15 (on `nak_irq_en[0]`..`nak_irq_en[3]`), and connect at bit 16.
- R3: Bits 10, 17 to 23, 27 and 29 to 31 always read zero, and writes to them have no effect. Bit 28 is read-only.
- R4: A `bus_reset` pulse clears the address to zero at the next clock edge. It overrides a write to the address in the same cycle and leaves the other fields unchanged. It also sets the reset-change flag at bit 26 (`rst_chg`).
- R5: A `setup_ack` pulse sets the SETUP flag at bit 8. `nak_all` is high while the flag is set. Writing one to bit 8 clears the flag, and writing zero leaves it set.
- R6: The filtered VBUS level, at bit 28, is high from the first clock edge at which `vbus_raw` is high. It falls on the edge that samples the DEBOUNCE_TICKS-th `ms_tick` (default 3) counted while `vbus_raw` stays low. Any high sample of `vbus_raw` restarts the count.
- R7: `pullup_en` is high exactly when the connect bit 16 is set and the filtered VBUS level is high.
- R8: The connect-change flag at bit 24 (`conn_chg`) is set on the edge where the filtered VBUS level falls while the connect bit is set. It is not set when the connect bit is clear.
- R9: A `suspend_toggle` pulse sets the suspend-change flag at bit 25 (`susp_chg`).
- R10: Writing one to bit 24, 25 or 26 clears that flag, and writing zero leaves it unchanged. If a hardware set and a clearing write reach the same flag (bits 8, 24, 25, 26) in the same cycle, the flag stays set.
- R11: `clk_req` is high when the force-clock bit 9 is set or the filtered VBUS level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| bus_reset | input | 1 | USB bus reset detected (pulse) |
| setup_ack | input | 1 | SETUP token received and acknowledged (pulse) |
| vbus_raw | input | 1 | Unfiltered VBUS level |
| suspend_toggle | input | 1 | Suspend state changed (pulse) |
| dev_addr | output | 7 | Current function address |
| dev_active | output | 1 | Respond to `dev_addr` |
| nak_irq_en | output | 4 | Interrupt-on-NAK: [0] bulk/int OUT, [1] bulk/int IN, [2] control OUT, [3] control IN |
| nak_all | output | 1 | NAK all IN and OUT tokens |
| pullup_en | output | 1 | Enable the D+ pull-up |
| clk_req | output | 1 | Request the USB clock |
| conn_chg | output | 1 | Connect-change flag |
| susp_chg | output | 1 | Suspend-change flag |
| rst_chg | output | 1 | Reset-change flag |

## Verification
Every stored field, flag and the filtered VBUS level is a single register stage. A write or event pulse held across one rising edge is therefore visible on `reg_rdata` and the outputs just after that edge. `pullup_en` and `clk_req` are combinational from those registers and share the same timing. The bench changes inputs one time unit after a rising edge and checks one time unit after the next rising edge, so each result is sampled in the cycle it becomes due. For the VBUS fall, the bench checks the level after the tick before last, where it must still be high, and again after the last tick, where it must have dropped.

// File: rtl/usbd_cs_pkg.sv
package usbd_cs_pkg;
   localparam int REG_W       = 32;
   localparam int ADDR_W      = 7;
   localparam int NAKIE_W     = 4;
   // field positions that software decodes
   localparam int P_EN        = 7;
   localparam int P_SETUP     = 8;
   localparam int P_FORCECLK  = 9;
   localparam int P_LPM       = 11;
   localparam int P_NAKIE     = 12;
   localparam int P_CONN      = 16;
   localparam int P_CONN_CHG  = 24;
   localparam int P_SUSP_CHG  = 25;
   localparam int P_RST_CHG   = 26;
   localparam int P_VBUS      = 28;

   typedef enum logic [1:0] {
      FLG_SETUP = 2'd0,
      FLG_CONN  = 2'd1,
      FLG_SUSP  = 2'd2,
      FLG_RST   = 2'd3
   } flag_idx_e;
   localparam int NUM_FLAGS = 4;
endpackage

// File: rtl/usbd_sticky.sv
module usbd_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   // R10: a hardware set beats a same-cycle clearing write
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/usbd_vbus_filter.sv
module usbd_vbus_filter #(
   parameter int TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vbus_i,
   input  logic tick_i,
   output logic level_o,
   output logic fall_o
);
   localparam int CW = $clog2(TICKS + 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("usbd_vbus_filter: TICKS must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          level_d;

   always_comb begin
      level_d = level_o;
      if (vbus_i)
         level_d = 1'b1;
      else if (level_o && tick_i && cnt_q == CW'(TICKS - 1))
         level_d = 1'b0;
   end

   assign fall_o = level_o & ~level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= 1'b0;
         cnt_q   <= '0;
      end else begin
         level_o <= level_d;
         if (vbus_i || !level_o)
            cnt_q <= '0;
         else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: rising is immediate, falling needs VBUS to have been low
   p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vbus_i |=> level_o);
   p_fall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(level_o) |-> !$past(vbus_i));
endmodule

// File: rtl/usbd_cmdstat.sv
module usbd_cmdstat
   import usbd_cs_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int DEBOUNCE_TICKS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ms_tick,
   input  logic              bus_reset,
   input  logic              setup_ack,
   input  logic              vbus_raw,
   input  logic              suspend_toggle,
   output logic [6:0]        dev_addr,
   output logic              dev_active,
   output logic [3:0]        nak_irq_en,
   output logic              nak_all,
   output logic              pullup_en,
   output logic              clk_req,
   output logic              conn_chg,
   output logic              susp_chg,
   output logic              rst_chg
);
   if (DATA_W != REG_W) begin : g_bad_width
      $error("usbd_cmdstat: DATA_W must equal %0d", REG_W);
   end

   logic [ADDR_W-1:0]    addr_q;
   logic                 en_q, fclk_q, lpm_q, conn_q;
   logic [NAKIE_W-1:0]   nakie_q;
   logic                 vbus_lvl, vbus_fall;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

   // ---------------- software-owned fields ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         en_q    <= 1'b0;
         fclk_q  <= 1'b0;
         lpm_q   <= 1'b1;
         nakie_q <= '0;
         conn_q  <= 1'b0;
      end else begin
         if (reg_wr) begin
            addr_q  <= reg_wdata[ADDR_W-1:0];
            en_q    <= reg_wdata[P_EN];
            fclk_q  <= reg_wdata[P_FORCECLK];
            lpm_q   <= reg_wdata[P_LPM];
            nakie_q <= reg_wdata[P_NAKIE +: NAKIE_W];
            conn_q  <= reg_wdata[P_CONN];
         end
         if (bus_reset)
            addr_q <= '0;
      end
   end

   // ---------------- VBUS filter ----------------
   usbd_vbus_filter #(.TICKS(DEBOUNCE_TICKS)) u_vbus (
      .clk     (clk),
      .rst_n   (rst_n),
      .vbus_i  (vbus_raw),
      .tick_i  (ms_tick),
      .level_o (vbus_lvl),
      .fall_o  (vbus_fall)
   );

   // ---------------- sticky flags ----------------
   always_comb begin
      flag_set           = '0;
      flag_set[FLG_SETUP] = setup_ack;
      flag_set[FLG_CONN]  = vbus_fall & conn_q;
      flag_set[FLG_SUSP]  = suspend_toggle;
      flag_set[FLG_RST]   = bus_reset;
      flag_clr           = '0;
      flag_clr[FLG_SETUP] = reg_wr & reg_wdata[P_SETUP];
      flag_clr[FLG_CONN]  = reg_wr & reg_wdata[P_CONN_CHG];
      flag_clr[FLG_SUSP]  = reg_wr & reg_wdata[P_SUSP_CHG];
      flag_clr[FLG_RST]   = reg_wr & reg_wdata[P_RST_CHG];
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      usbd_sticky u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (flag_set[i]),
         .clr_i (flag_clr[i]),
         .q_o   (flag_q[i])
      );
   end

   // ---------------- outputs ----------------
   assign dev_addr   = addr_q;
   assign dev_active = en_q;
   assign nak_irq_en = nakie_q;
   assign nak_all    = flag_q[FLG_SETUP];
   assign pullup_en  = conn_q & vbus_lvl;
   assign clk_req    = fclk_q | vbus_lvl;
   assign conn_chg   = flag_q[FLG_CONN];
   assign susp_chg   = flag_q[FLG_SUSP];
   assign rst_chg    = flag_q[FLG_RST];

   always_comb begin
      reg_rdata                        = '0;
      reg_rdata[ADDR_W-1:0]            = addr_q;
      reg_rdata[P_EN]                  = en_q;
      reg_rdata[P_SETUP]               = flag_q[FLG_SETUP];
      reg_rdata[P_FORCECLK]            = fclk_q;
      reg_rdata[P_LPM]                 = lpm_q;
      reg_rdata[P_NAKIE +: NAKIE_W]    = nakie_q;
      reg_rdata[P_CONN]                = conn_q;
      reg_rdata[P_CONN_CHG]            = flag_q[FLG_CONN];
      reg_rdata[P_SUSP_CHG]            = flag_q[FLG_SUSP];
      reg_rdata[P_RST_CHG]             = flag_q[FLG_RST];
      reg_rdata[P_VBUS]                = vbus_lvl;
   end

   // R4: bus reset always zeroes the address
   p_addr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (dev_addr == '0));
   // R5: an acknowledged SETUP forces NAK on the next cycle
   p_nak_after_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      setup_ack |=> nak_all);
   // R8: losing VBUS while connected is recorded
   p_conn_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_en && vbus_fall) |=> conn_chg);
   // R4: the reset-change flag follows a bus reset
   p_rst_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> rst_chg);
endmodule

// File: tb/usbd_cmdstat_bench.sv
module usbd_cmdstat_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICKS      = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ms_tick = 1'b0, bus_reset = 1'b0, setup_ack = 1'b0;
   logic        vbus_raw = 1'b0, suspend_toggle = 1'b0;
   logic [6:0]  dev_addr;
   logic        dev_active, nak_all, pullup_en, clk_req;
   logic        conn_chg, susp_chg, rst_chg;
   logic [3:0]  nak_irq_en;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbd_cmdstat #(.DATA_W(32), .DEBOUNCE_TICKS(TICKS)) u_usbd_cmdstat (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ms_tick(ms_tick), .bus_reset(bus_reset),
      .setup_ack(setup_ack), .vbus_raw(vbus_raw),
      .suspend_toggle(suspend_toggle), .dev_addr(dev_addr),
      .dev_active(dev_active), .nak_irq_en(nak_irq_en), .nak_all(nak_all),
      .pullup_en(pullup_en), .clk_req(clk_req), .conn_chg(conn_chg),
      .susp_chg(susp_chg), .rst_chg(rst_chg)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic tick1();
      ms_tick = 1'b1; step(); ms_tick = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rdata", reg_rdata, 32'h0000_0800);
      chk("R1 outs", {28'd0, pullup_en, nak_all, clk_req, conn_chg|susp_chg|rst_chg}, 32'd0);
   endtask

   task automatic t_fields();
      wr(32'hFFFF_FFFF);
      chk("R3 rdata all-ones", reg_rdata, 32'h0001_FAFF);
      chk("R2 addr/en", {24'd0, dev_active, dev_addr}, 32'h0000_00FF);
      chk("R2 nakie", {28'd0, nak_irq_en}, 32'hF);
      chk("R11 clk_req forced", {31'd0, clk_req}, 32'd1);
      wr(32'h0000_0000);
      chk("R2 cleared", reg_rdata, 32'h0);
      chk("R11 clk_req off", {31'd0, clk_req}, 32'd0);
      wr(32'hE8E0_5C55);
      chk("R3 reserved ignored", reg_rdata, 32'h0000_5855);
      chk("R2 nakie order", {28'd0, nak_irq_en}, 32'h5);
      chk("R2 addr", {25'd0, dev_addr}, 32'h55);
   endtask

   task automatic t_bus_reset();
      reg_wr = 1'b1; reg_wdata = 32'h0000_08B3; bus_reset = 1'b1;
      step();
      reg_wr = 1'b0; reg_wdata = '0; bus_reset = 1'b0;
      chk("R4 reset beats write", reg_rdata, 32'h0400_0880);
      chk("R4 rst_chg", {31'd0, rst_chg}, 32'd1);
      wr(32'h0000_0880);
      chk("R10 write zero keeps", reg_rdata, 32'h0400_0880);
      wr(32'h0400_0880);
      chk("R10 w1c rst", reg_rdata, 32'h0000_0880);
   endtask

   task automatic t_setup();
      setup_ack = 1'b1; step(); setup_ack = 1'b0;
      chk("R5 setup set", reg_rdata, 32'h0000_0980);
      chk("R5 nak_all", {31'd0, nak_all}, 32'd1);
      wr(32'h0000_0880);
      chk("R5 zero keeps", {31'd0, nak_all}, 32'd1);
      setup_ack = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_0980;
      step();
      setup_ack = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      chk("R10 set wins", reg_rdata, 32'h0000_0980);
      wr(32'h0000_0980);
      chk("R5 w1c", {31'd0, nak_all}, 32'd0);
   endtask

   task automatic t_vbus();
      vbus_raw = 1'b1; step();
      chk("R6 rise", reg_rdata, 32'h1000_0880);
      chk("R7 no conn", {31'd0, pullup_en}, 32'd0);
      chk("R11 clk_req vbus", {31'd0, clk_req}, 32'd1);
      wr(32'h0001_0880);
      chk("R7 pullup on", {31'd0, pullup_en}, 32'd1);
      vbus_raw = 1'b0;
      repeat (5) step();
      tick1(); tick1();
      chk("R6 held", {31'd0, reg_rdata[28]}, 32'd1);
      vbus_raw = 1'b1; step(); vbus_raw = 1'b0;
      tick1(); tick1();
      chk("R6 restart", {31'd0, reg_rdata[28]}, 32'd1);
      tick1();
      chk("R6 fall", reg_rdata, 32'h0101_0880);
      chk("R7 pullup off", {31'd0, pullup_en}, 32'd0);
      chk("R8 conn_chg", {31'd0, conn_chg}, 32'd1);
      wr(32'h0101_0880);
      chk("R10 w1c conn", reg_rdata, 32'h0001_0880);
      wr(32'h0000_0880);
      vbus_raw = 1'b1; step(); vbus_raw = 1'b0;
      for (int i = 0; i < TICKS; i++) tick1();
      chk("R8 no conn no flag", reg_rdata, 32'h0000_0880);
   endtask

   task automatic t_susp();
      suspend_toggle = 1'b1; step(); suspend_toggle = 1'b0;
      chk("R9 susp_chg", reg_rdata, 32'h0200_0880);
      wr(32'h0200_0880);
      chk("R10 w1c susp", {31'd0, susp_chg}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_fields();
      t_bus_reset();
      t_setup();
      t_vbus();
      t_susp();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule